// File: doc/BRIEF.md
# Single-Precision Rounding Packer

This block turns an unpacked floating-point value into a 32-bit IEEE-754 single-precision word and its exception flags. The value arrives as a class code, a sign, a signed unbiased exponent, a significand with an explicit leading one at its top bit, two extra bits below the significand (guard and round) and a sticky bit that stands for everything further down. A two-bit rounding-mode input and an underflow-trap-enable input come with each value.

For finite numbers the block works out the biased exponent. Results too small for a normal encoding are shifted right into subnormal position before rounding. The block then rounds in the selected mode, corrects the exponent when the significand carries out, and replaces results that are too large with either infinity or the largest finite value. Zero, infinity and NaN inputs skip the rounding path. Inputs and outputs use a valid/ready handshake with a single output register, so the result appears one cycle after acceptance and holds while the consumer stalls. The flags are per result. Accumulating them is up to the surrounding logic.

Top module: `sp_pack_round`

## Requirements
- R1: When guard, round and sticky are all zero and the result fits, the word is the exact packed value (sign bit 31, biased exponent bits 30:23 with bias 127, fraction bits 22:0) and no flag is raised.
- R2: With roundMode 00 (nearest), the value is incremented only if guard is set and at least one of round, sticky or the kept LSB is also set. An exact tie therefore goes to the even neighbour.
- R3: roundMode 01 (toward zero) never increments. Mode 10 (toward plus infinity) increments only positive inexact values. Mode 11 (toward minus infinity) increments only negative inexact values.
- R4: outInexact is set whenever any of guard, round or sticky (including bits shifted out during denormalisation) is nonzero. outRoundedUp is set exactly when an increment was applied, and it never appears without outInexact.
- R5: When rounding carries a normal significand to 2.0, the biased exponent goes up by one and the fraction field is zero.
- R6: A biased exponent of 255 or more after rounding is an overflow. It produces signed infinity in nearest mode, and in a directed mode that rounds away from zero for that sign. Otherwise it produces exponent 254 with an all-ones fraction. outOverflow is set only when infinity is produced, and the overflow word always has exponent 255.
- R7: A biased exponent of zero or below yields a subnormal. The significand, leading one included, is shifted right by one plus the deficit before rounding. Bits shifted out join the sticky bit, and the exponent field is 0.
- R8: A subnormal that rounds up into the smallest normal produces exponent 1 with fraction 0 and raises no underflow, even with the trap enable set.
- R9: A result that remains subnormal raises outUnderflow if it was inexact or if uflowTrapEn is set. An underflow result always has exponent field 0.
- R10: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN. Zero gives the sign bit alone. Infinity gives exponent 255 with fraction 0. Either NaN gives exponent 255, fraction bit 22 forced to one and fraction bits 21:0 taken from the significand bits just below its top two. None of them raises a flag, whatever the guard and sticky inputs are.
- R11: An input accepted with inValid and inReady high appears with outValid one clock later. While outValid is high and outReady is low, the output stays unchanged and inReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input value is present |
| inReady | output | 1 | Block can accept an input this cycle |
| inClass | input | 3 | Class code of the input value |
| inSign | input | 1 | Sign of the input value |
| inExp | input | EXP_W | Signed unbiased exponent |
| inMant | input | MANT_W | Significand with explicit leading one at the top bit |
| inGuard | input | 2 | Guard (bit 1) and round (bit 0) bits below the significand |
| inSticky | input | 1 | OR of all lower bits |
| roundMode | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| uflowTrapEn | input | 1 | Underflow trap enable, forces the underflow flag on subnormal results |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result this cycle |
| outWord | output | 32 | Packed single-precision result |
| outInexact | output | 1 | Result was rounded |
| outRoundedUp | output | 1 | Rounding incremented the magnitude |
| outOverflow | output | 1 | Overflow delivered as infinity |
| outUnderflow | output | 1 | Subnormal result that was inexact or trapped |

## Verification
The hardest situations to reach are the ones where two boundaries meet in one value. One is a subnormal whose rounding carry promotes it to the smallest normal while the trap enable is set, which checks that promotion suppresses underflow. The other is a value one step below the largest finite number whose tie-break rounding pushes the exponent to 255. The vector table builds these from chosen exponents (biased 0 with an all-ones significand and both extra bits set; biased 254 with an odd all-ones significand and a bare guard bit). It also builds an exponent hundreds of steps below the subnormal range, so the whole significand is shifted into sticky and only a directed mode can produce the lowest subnormal.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } valClass_e;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_ZERO  = 2'b01,
    RM_PLUS  = 2'b10,
    RM_MINUS = 2'b11
  } roundMode_e;

  localparam int SP_FRAC_W = 23;
  localparam int SP_SIG_W  = 24;
  localparam int SP_BIAS   = 127;
  localparam logic [7:0] SP_EXP_MAX = 8'hFF;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

endpackage

// File: rtl/sp_pack_ctrl.sv
module sp_pack_ctrl
  import sp_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);

  logic validQ;

  assign inReady    = !validQ || outReady;
  assign strobe.load = inValid && inReady;
  assign outValid   = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

endmodule

// File: rtl/sp_pack_dpath.sv
module sp_pack_dpath
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        inClass,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMant,
  input  logic [1:0]        inGuard,
  input  logic              inSticky,
  input  logic [1:0]        roundMode,
  input  logic              uflowTrapEn,
  output logic [31:0]       outWord,
  output logic              outInexact,
  output logic              outRoundedUp,
  output logic              outOverflow,
  output logic              outUnderflow
);

  localparam int FULL_W     = MANT_W + 2;
  localparam int PRE_SHIFT  = MANT_W - SP_SIG_W;
  localparam int BX_W       = EXP_W + 2;
  localparam int SH_W       = BX_W + 1;

  // Biased exponent and subnormal detection
  logic signed [BX_W-1:0] biased;
  logic                   isSub;
  logic [BX_W-1:0]        deficit;
  logic [SH_W-1:0]        shAmt;

  assign biased  = $signed({{2{inExp[EXP_W-1]}}, inExp}) + $signed(BX_W'(SP_BIAS));
  assign isSub   = biased[BX_W-1] || (biased == '0);
  assign deficit = BX_W'(-biased);
  assign shAmt   = isSub ? SH_W'(PRE_SHIFT + 1) + SH_W'(deficit) : SH_W'(PRE_SHIFT);

  // Alignment shift: everything shifted out joins sticky
  logic [FULL_W-1:0] fullVal, shifted, restored;
  logic              lostBits;

  assign fullVal  = {inMant, inGuard};
  assign shifted  = fullVal >> shAmt;
  assign restored = shifted << shAmt;
  assign lostBits = (restored != fullVal);

  logic [SP_SIG_W-1:0] kept;
  logic [1:0]          gr;
  logic                stk;
  logic                inexact;
  logic                bump;

  assign kept    = shifted[SP_SIG_W+1:2];
  assign gr      = shifted[1:0];
  assign stk     = lostBits || inSticky;
  assign inexact = (gr != 2'b00) || stk;

  always_comb begin
    unique case (roundMode_e'(roundMode))
      RM_NEAR:  bump = gr[1] && (gr[0] || stk || kept[0]);
      RM_ZERO:  bump = 1'b0;
      RM_PLUS:  bump = inexact && !inSign;
      RM_MINUS: bump = inexact && inSign;
      default:  bump = 1'b0;
    endcase
  end

  logic [SP_SIG_W:0]   sum;
  logic [BX_W-1:0]     expAdj;
  logic                ovf;
  logic                toInf;

  assign sum    = {1'b0, kept} + (SP_SIG_W+1)'(bump);
  assign expAdj = biased + BX_W'(sum[SP_SIG_W]);
  assign ovf    = !isSub && (expAdj >= BX_W'(255));

  always_comb begin
    unique case (roundMode_e'(roundMode))
      RM_NEAR:  toInf = 1'b1;
      RM_ZERO:  toInf = 1'b0;
      RM_PLUS:  toInf = !inSign;
      RM_MINUS: toInf = inSign;
      default:  toInf = 1'b1;
    endcase
  end

  // NaN payload: keep upper fraction bits, force quiet bit
  logic [SP_FRAC_W-1:0] nanFrac;
  generate
    if (MANT_W - 2 >= SP_FRAC_W - 1) begin : g_nanTrunc
      assign nanFrac = {1'b1, inMant[MANT_W-3 -: SP_FRAC_W-1]};
    end else begin : g_nanPad
      assign nanFrac = {1'b1, inMant[MANT_W-3:0], {(SP_FRAC_W+1-MANT_W){1'b0}}};
    end
  endgenerate

  // Result selection
  logic [31:0] nxtWord;
  logic        nxtInexact, nxtUp, nxtOvf, nxtUf;

  always_comb begin
    nxtWord    = {inSign, 31'd0};
    nxtInexact = 1'b0;
    nxtUp      = 1'b0;
    nxtOvf     = 1'b0;
    nxtUf      = 1'b0;
    unique case (valClass_e'(inClass))
      CLS_ZERO: nxtWord = {inSign, 31'd0};
      CLS_INF:  nxtWord = {inSign, SP_EXP_MAX, {SP_FRAC_W{1'b0}}};
      CLS_QNAN,
      CLS_SNAN: nxtWord = {inSign, SP_EXP_MAX, nanFrac};
      CLS_NUM: begin
        nxtInexact = inexact;
        nxtUp      = bump;
        if (isSub) begin
          // sum[23] set means promotion to exponent 1, fraction 0
          nxtWord = {inSign, 7'd0, sum[SP_SIG_W-1], sum[SP_FRAC_W-1:0]};
          nxtUf   = !sum[SP_SIG_W-1] && (inexact || uflowTrapEn);
        end else if (ovf) begin
          nxtOvf  = toInf;
          nxtWord = toInf ? {inSign, SP_EXP_MAX, {SP_FRAC_W{1'b0}}}
                          : {inSign, 8'hFE, {SP_FRAC_W{1'b1}}};
        end else begin
          nxtWord = {inSign, expAdj[7:0], sum[SP_FRAC_W-1:0]};
        end
      end
      default: nxtWord = {inSign, 31'd0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWord      <= '0;
      outInexact   <= 1'b0;
      outRoundedUp <= 1'b0;
      outOverflow  <= 1'b0;
      outUnderflow <= 1'b0;
    end else if (strobe.load) begin
      outWord      <= nxtWord;
      outInexact   <= nxtInexact;
      outRoundedUp <= nxtUp;
      outOverflow  <= nxtOvf;
      outUnderflow <= nxtUf;
    end
  end

endmodule

// File: rtl/sp_pack_round.sv
module sp_pack_round
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inClass,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMant,
  input  logic [1:0]        inGuard,
  input  logic              inSticky,
  input  logic [1:0]        roundMode,
  input  logic              uflowTrapEn,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outWord,
  output logic              outInexact,
  output logic              outRoundedUp,
  output logic              outOverflow,
  output logic              outUnderflow
);

  ctrlStrobe_t strobe;

  sp_pack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  sp_pack_dpath #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .inClass      (inClass),
    .inSign       (inSign),
    .inExp        (inExp),
    .inMant       (inMant),
    .inGuard      (inGuard),
    .inSticky     (inSticky),
    .roundMode    (roundMode),
    .uflowTrapEn  (uflowTrapEn),
    .outWord      (outWord),
    .outInexact   (outInexact),
    .outRoundedUp (outRoundedUp),
    .outOverflow  (outOverflow),
    .outUnderflow (outUnderflow)
  );

endmodule

// File: rtl/sp_pack_checker.sv
module sp_pack_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic [2:0]  inClass,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outWord,
  input logic        outInexact,
  input logic        outRoundedUp,
  input logic        outOverflow,
  input logic        outUnderflow
);

  // R11: accepted input shows up one cycle later
  a_r11_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R11: stalled result holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));

  // R11: no acceptance while stalled
  a_r11_stall_ready: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R4: rounded-up implies inexact
  a_r4_up_inexact: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRoundedUp) |-> outInexact);

  // R6: overflow flag only with infinity
  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOverflow) |-> (outWord[30:0] == 31'h7F80_0000));

  // R9: underflow only on exponent field 0
  a_r9_uf_sub: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUnderflow) |-> (outWord[30:23] == 8'd0));

  // R10: zero class gives sign only and no flags
  a_r10_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inClass == 3'd0) |=>
      (outWord[30:0] == 31'd0 && !outInexact && !outOverflow && !outUnderflow));

endmodule

bind sp_pack_round sp_pack_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inReady      (inReady),
  .inClass      (inClass),
  .outValid     (outValid),
  .outReady     (outReady),
  .outWord      (outWord),
  .outInexact   (outInexact),
  .outRoundedUp (outRoundedUp),
  .outOverflow  (outOverflow),
  .outUnderflow (outUnderflow)
);

// File: tb/sim_sp_pack_round.sv
module sim_sp_pack_round;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_W  = 10;
  localparam int MANT_W = 24;

  typedef struct packed {
    logic [2:0]  cls;
    logic        sign;
    logic [9:0]  exp;
    logic [23:0] mant;
    logic [1:0]  gr;
    logic        stk;
    logic [1:0]  rm;
    logic        trap;
    logic [31:0] word;
    logic [3:0]  flags;   // {inexact, roundedUp, overflow, underflow}
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1,1'b0,10'h000,24'h800000,2'b00,1'b0,2'b00,1'b0,32'h3F800000,4'b0000,4'd1},  // R1 exact
    '{3'd1,1'b0,10'h000,24'h800001,2'b10,1'b0,2'b00,1'b0,32'h3F800002,4'b1100,4'd2},  // R2 tie odd
    '{3'd1,1'b0,10'h000,24'h800000,2'b10,1'b0,2'b00,1'b0,32'h3F800000,4'b1000,4'd2},  // R2 tie even
    '{3'd1,1'b0,10'h000,24'h800000,2'b10,1'b1,2'b00,1'b0,32'h3F800001,4'b1100,4'd2},  // R2 above half
    '{3'd1,1'b0,10'h000,24'h800000,2'b01,1'b0,2'b00,1'b0,32'h3F800000,4'b1000,4'd2},  // R2 below half
    '{3'd1,1'b0,10'h000,24'h800000,2'b11,1'b1,2'b01,1'b0,32'h3F800000,4'b1000,4'd3},  // R3 toward zero
    '{3'd1,1'b0,10'h000,24'h800000,2'b01,1'b0,2'b10,1'b0,32'h3F800001,4'b1100,4'd3},  // R3 plus, positive
    '{3'd1,1'b1,10'h000,24'h800000,2'b01,1'b0,2'b10,1'b0,32'hBF800000,4'b1000,4'd3},  // R3 plus, negative
    '{3'd1,1'b1,10'h000,24'h800000,2'b01,1'b0,2'b11,1'b0,32'hBF800001,4'b1100,4'd3},  // R3 minus, negative
    '{3'd1,1'b0,10'h000,24'h800000,2'b00,1'b1,2'b11,1'b0,32'h3F800000,4'b1000,4'd4},  // R4 sticky only
    '{3'd1,1'b0,10'h000,24'hFFFFFF,2'b11,1'b0,2'b00,1'b0,32'h40000000,4'b1100,4'd5},  // R5 carry to 2.0
    '{3'd1,1'b0,10'h07F,24'hFFFFFF,2'b10,1'b0,2'b00,1'b0,32'h7F800000,4'b1110,4'd6},  // R6 round into ovf
    '{3'd1,1'b0,10'h080,24'h800000,2'b00,1'b0,2'b01,1'b0,32'h7F7FFFFF,4'b0000,4'd6},  // R6 zero mode max
    '{3'd1,1'b1,10'h080,24'h800000,2'b00,1'b0,2'b10,1'b0,32'hFF7FFFFF,4'b0000,4'd6},  // R6 plus, negative
    '{3'd1,1'b1,10'h080,24'h800000,2'b00,1'b0,2'b11,1'b0,32'hFF800000,4'b0010,4'd6},  // R6 minus, negative
    '{3'd1,1'b0,10'h0C8,24'h800000,2'b00,1'b0,2'b00,1'b0,32'h7F800000,4'b0010,4'd6},  // R6 far ovf
    '{3'd1,1'b0,10'h381,24'h800000,2'b00,1'b0,2'b00,1'b0,32'h00400000,4'b0000,4'd7},  // R7 exact subnormal
    '{3'd1,1'b0,10'h37E,24'h800001,2'b00,1'b0,2'b00,1'b0,32'h00080000,4'b1001,4'd7},  // R7 lost bits
    '{3'd1,1'b0,10'h381,24'h800000,2'b00,1'b0,2'b00,1'b1,32'h00400000,4'b0001,4'd9},  // R9 trap exact
    '{3'd1,1'b0,10'h381,24'hFFFFFF,2'b11,1'b0,2'b00,1'b1,32'h00800000,4'b1100,4'd8},  // R8 promote
    '{3'd0,1'b1,10'h000,24'h000000,2'b11,1'b1,2'b10,1'b0,32'h80000000,4'b0000,4'd10}, // R10 zero
    '{3'd2,1'b1,10'h000,24'h800000,2'b11,1'b1,2'b00,1'b0,32'hFF800000,4'b0000,4'd10}, // R10 inf
    '{3'd3,1'b0,10'h000,24'hC00001,2'b10,1'b1,2'b00,1'b0,32'h7FC00001,4'b0000,4'd10}, // R10 quiet NaN
    '{3'd4,1'b1,10'h000,24'h800005,2'b00,1'b0,2'b00,1'b0,32'hFFC00005,4'b0000,4'd10}, // R10 signalling NaN
    '{3'd1,1'b0,10'h2D4,24'h800000,2'b00,1'b0,2'b10,1'b0,32'h00000001,4'b1101,4'd9}   // R9 deep subnormal
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [2:0]        inClass = '0;
  logic              inSign = 1'b0;
  logic [EXP_W-1:0]  inExp = '0;
  logic [MANT_W-1:0] inMant = '0;
  logic [1:0]        inGuard = '0;
  logic              inSticky = 1'b0;
  logic [1:0]        roundMode = '0;
  logic              uflowTrapEn = 1'b0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [31:0]       outWord;
  logic              outInexact, outRoundedUp, outOverflow, outUnderflow;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_pack_round #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inClass(inClass), .inSign(inSign), .inExp(inExp), .inMant(inMant),
    .inGuard(inGuard), .inSticky(inSticky), .roundMode(roundMode),
    .uflowTrapEn(uflowTrapEn), .outValid(outValid), .outReady(outReady),
    .outWord(outWord), .outInexact(outInexact), .outRoundedUp(outRoundedUp),
    .outOverflow(outOverflow), .outUnderflow(outUnderflow)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    inClass = v.cls; inSign = v.sign; inExp = v.exp; inMant = v.mant;
    inGuard = v.gr; inSticky = v.stk; roundMode = v.rm; uflowTrapEn = v.trap;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!outValid && inReady, "R11 reset", {62'd0, outValid, inReady}, 64'd1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      inValid = 1'b1;
      outReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      inValid = 1'b0;
      check(outValid && outWord == VECS[i].word &&
            {outInexact, outRoundedUp, outOverflow, outUnderflow} == VECS[i].flags,
            $sformatf("R%0d vector %0d", VECS[i].req, i),
            {27'd0, outValid, outInexact, outRoundedUp, outOverflow, outUnderflow, outWord},
            {27'd0, 1'b1, VECS[i].flags, VECS[i].word});
    end

    // R11 backpressure: hold and refuse new input
    @(negedge clk);
    drive(VECS[1]);
    inValid = 1'b1;
    outReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(outValid && outWord == 32'h3F800002, "R11 first capture", {31'd0, outValid, outWord}, {31'd0, 1'b1, 32'h3F800002});
    check(!inReady, "R11 ready low while stalled", {63'd0, inReady}, 64'd0);
    drive(VECS[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid && outWord == 32'h3F800002, "R11 hold under stall", {31'd0, outValid, outWord}, {31'd0, 1'b1, 32'h3F800002});
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid && outWord == 32'h3F800000, "R11 accept on release", {31'd0, outValid, outWord}, {31'd0, 1'b1, 32'h3F800000});
    @(posedge clk);
    @(negedge clk);
    check(!outValid, "R11 drain", {63'd0, outValid}, 64'd0);

    // R8 promotion without trap also raises no underflow
    drive(VECS[19]);
    uflowTrapEn = 1'b0;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(outWord == 32'h00800000 && !outUnderflow, "R8 promote no trap",
          {31'd0, outUnderflow, outWord}, {32'd0, 32'h00800000});

    // R5 carry in negative value via minus mode
    drive(VECS[10]);
    inSign = 1'b1;
    roundMode = 2'b11;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(outWord == 32'hC0000000 && outRoundedUp, "R5 negative carry",
          {31'd0, outRoundedUp, outWord}, {31'd0, 1'b1, 32'hC0000000});

    finish_run();
  end

endmodule